// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast PLL clock by a programmable integer ratio and hands one short pulse per divided period to the phase/frequency detector. The ratio is set by two small settings: a base count `B` (6 bits) and an extension count `A` (2 bits). Inside each output period a 4/5 prescaler runs `B` prescaler cycles in total. The first `A` of them last five input clocks and the rest last four, so the period is `N = 4*B + A` input clocks, from 16 up to 255.

The settings are taken only when one period ends and the next begins, so a period never mixes old and new values. A setting outside the legal range raises an error flag. While the flag is up the divider keeps running on the last legal setting. The integration is simple: drive `B` and `A` from a configuration register, feed the pulse to the detector and watch the error flag.

Top module: `fbdiv_dualmod`

## Requirements
- R1: For every legal pair (B from 4 to 63, A from 0 to 3), consecutive output pulses are exactly 4*B + A input clocks apart.
- R2: Each output pulse is high for exactly one input clock.
- R3: After reset is released, the first output pulse is high following the N-th rising edge, where N comes from the B and A values present at the first rising edge.
- R4: B and A are sampled only at the rising edge that ends a pulse cycle (or the first edge after reset). A change at any other time first affects the period that starts at the next such edge.
- R5: The error flag is high one clock after B < 4 or A > B is presented, and low one clock after a legal pair is presented.
- R6: While the inputs are illegal at a sampling edge, the divider keeps the period of the last legal setting.
- R7: During reset the pulse and the error flag are low, and the active setting is B = 4, A = 0. If the inputs are illegal at the first edge after reset, the first period is 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted in step with clk_i |
| b_val_i | input | 6 | Base count B (legal 4..63) |
| a_val_i | input | 2 | Extension count A (legal 0..3, and not above B) |
| div_pulse_o | output | 1 | One-clock pulse, once per N input clocks |
| cfg_err_o | output | 1 | Registered flag for an illegal B/A pair |

## Verification
The pulse is registered, so it is visible after the N-th rising edge of a period. The bench drives inputs and samples outputs on falling edges, and counts falling edges from one pulse to the next so that the count is the period itself. The error flag is due one edge after the inputs change and is read at the following falling edge. Settings are changed on the falling edge where the pulse is high, so that they take effect at once. For the hold check they are changed a few clocks later, and there the running period must keep its old length and the next period must take the new one.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Fixed low modulus of the dual-modulus prescaler; the high modulus is one more.
  localparam int unsigned PSC_BASE  = 4;
  // Counter wide enough to hold PSC_BASE + 1.
  localparam int unsigned PSC_CNT_W = 3;

  typedef logic [PSC_CNT_W-1:0] psc_cnt_t;

  typedef enum logic {
    PSC_DIV_BASE = 1'b0,
    PSC_DIV_EXT  = 1'b1
  } psc_mod_e;

  // Clocks still to run in a prescaler cycle at its start. When the cycle
  // begins on the period-load edge, that edge has already used one clock.
  function automatic psc_cnt_t psc_len(psc_mod_e mode, logic on_load);
    int unsigned len;
    len = PSC_BASE;
    if (mode == PSC_DIV_EXT) len = len + 1;
    if (on_load)             len = len - 1;
    return psc_cnt_t'(len);
  endfunction

endpackage

// File: rtl/fbdiv_prescaler.sv
// Down counter for one prescaler cycle; term_o marks its final clock.
module fbdiv_prescaler
  import fbdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  psc_cnt_t start_len_i,
  output logic     term_o
);

  psc_cnt_t cnt_q, cnt_d;
  logic     cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q > psc_cnt_t'(1));
    cnt_d  = start_i ? start_len_i : (cnt_q - psc_cnt_t'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign term_o = (cnt_q == psc_cnt_t'(1));

endmodule

// File: rtl/fbdiv_seq.sv
// A/B sequencing: picks the modulus of each prescaler cycle and finds the period end.
module fbdiv_seq
  import fbdiv_pkg::*;
#(
  parameter int unsigned B_W = 6,
  parameter int unsigned A_W = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           term_i,
  input  logic [B_W-1:0] b_cfg_i,
  input  logic [A_W-1:0] a_cfg_i,
  output logic           start_o,
  output psc_cnt_t       start_len_o,
  output logic           last_o
);

  logic [A_W-1:0] ext_left_q, ext_left_d;
  logic [B_W-1:0] cyc_left_q, cyc_left_d;
  logic           left_en;
  psc_mod_e       nxt_mod;
  logic           on_load;

  always_comb begin
    ext_left_d = ext_left_q;
    cyc_left_d = cyc_left_q;
    left_en    = 1'b0;
    start_o    = 1'b0;
    last_o     = 1'b0;
    nxt_mod    = PSC_DIV_BASE;
    on_load    = 1'b0;
    if (load_i) begin
      // First edge of a period: the first prescaler cycle starts here.
      left_en    = 1'b1;
      start_o    = 1'b1;
      on_load    = 1'b1;
      cyc_left_d = b_cfg_i - B_W'(1);
      if (a_cfg_i != '0) begin
        nxt_mod    = PSC_DIV_EXT;
        ext_left_d = a_cfg_i - A_W'(1);
      end else begin
        ext_left_d = '0;
      end
    end else if (term_i) begin
      if (cyc_left_q == '0) begin
        last_o = 1'b1;
      end else begin
        left_en    = 1'b1;
        start_o    = 1'b1;
        cyc_left_d = cyc_left_q - B_W'(1);
        if (ext_left_q != '0) begin
          nxt_mod    = PSC_DIV_EXT;
          ext_left_d = ext_left_q - A_W'(1);
        end
      end
    end
    start_len_o = psc_len(nxt_mod, on_load);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_left_q <= '0;
      cyc_left_q <= '0;
    end else if (left_en) begin
      ext_left_q <= ext_left_d;
      cyc_left_q <= cyc_left_d;
    end
  end

endmodule

// File: rtl/fbdiv_cfg_guard.sv
// Range check of B/A and the active setting register loaded at period boundaries.
module fbdiv_cfg_guard #(
  parameter int unsigned B_W   = 6,
  parameter int unsigned A_W   = 2,
  parameter int unsigned B_MIN = 4,
  parameter int unsigned B_RST = 4,
  parameter int unsigned A_RST = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [B_W-1:0] b_in_i,
  input  logic [A_W-1:0] a_in_i,
  input  logic           take_i,
  output logic [B_W-1:0] b_use_o,
  output logic [A_W-1:0] a_use_o,
  output logic [B_W-1:0] b_act_o,
  output logic [A_W-1:0] a_act_o,
  output logic           err_o
);

  logic [B_W-1:0] b_act_q;
  logic [A_W-1:0] a_act_q;
  logic           err_q, err_d;
  logic           in_ok;
  logic           act_en;

  always_comb begin
    in_ok   = (b_in_i >= B_W'(B_MIN)) &&
              ({{(B_W-A_W){1'b0}}, a_in_i} <= b_in_i);
    err_d   = !in_ok;
    act_en  = take_i && in_ok;
    b_use_o = in_ok ? b_in_i : b_act_q;
    a_use_o = in_ok ? a_in_i : a_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_act_q <= B_W'(B_RST);
      a_act_q <= A_W'(A_RST);
    end else if (act_en) begin
      b_act_q <= b_in_i;
      a_act_q <= a_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign b_act_o = b_act_q;
  assign a_act_o = a_act_q;
  assign err_o   = err_q;

endmodule

// File: rtl/fbdiv_dualmod.sv
// Programmable feedback divider, N = 4*B + A, from a 4/5 prescaler and A/B counters.
module fbdiv_dualmod
  import fbdiv_pkg::*;
#(
  parameter int unsigned B_W   = 6,
  parameter int unsigned A_W   = 2,
  parameter int unsigned B_MIN = 4,
  parameter int unsigned B_RST = 4,
  parameter int unsigned A_RST = 0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [B_W-1:0] b_val_i,
  input  logic [A_W-1:0] a_val_i,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);

  logic           start_q;
  logic           pulse_q, pulse_d;
  logic           bnd;
  logic [B_W-1:0] b_use, b_act;
  logic [A_W-1:0] a_use, a_act;
  logic           psc_start, psc_term, per_last;
  psc_cnt_t       psc_len_v;

  // A period starts on the first edge after reset and on the edge after each pulse.
  assign bnd = start_q || pulse_q;

  fbdiv_cfg_guard #(
    .B_W  (B_W),
    .A_W  (A_W),
    .B_MIN(B_MIN),
    .B_RST(B_RST),
    .A_RST(A_RST)
  ) guard_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .b_in_i (b_val_i),
    .a_in_i (a_val_i),
    .take_i (bnd),
    .b_use_o(b_use),
    .a_use_o(a_use),
    .b_act_o(b_act),
    .a_act_o(a_act),
    .err_o  (cfg_err_o)
  );

  fbdiv_seq #(
    .B_W(B_W),
    .A_W(A_W)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (bnd),
    .term_i     (psc_term),
    .b_cfg_i    (b_use),
    .a_cfg_i    (a_use),
    .start_o    (psc_start),
    .start_len_o(psc_len_v),
    .last_o     (per_last)
  );

  fbdiv_prescaler psc_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (psc_start),
    .start_len_i(psc_len_v),
    .term_o     (psc_term)
  );

  always_comb begin
    pulse_d = per_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      pulse_q <= pulse_d;
    end
  end

  assign div_pulse_o = pulse_q;

endmodule

// File: rtl/fbdiv_dualmod_chk.sv
module fbdiv_dualmod_chk #(
  parameter int unsigned B_W   = 6,
  parameter int unsigned A_W   = 2,
  parameter int unsigned B_MIN = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [B_W-1:0] b_val_i,
  input logic [A_W-1:0] a_val_i,
  input logic           div_pulse_o,
  input logic           cfg_err_o,
  input logic           start_q,
  input logic [B_W-1:0] b_act,
  input logic [A_W-1:0] a_act
);

  localparam int unsigned GAP_W = B_W + 3;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] n_exp;
  logic             bad_in;

  always_comb begin
    n_exp  = (GAP_W'(b_act) << 2) + GAP_W'(a_act);
    bad_in = (b_val_i < B_W'(B_MIN)) ||
             ({{(B_W-A_W){1'b0}}, a_val_i} > b_val_i);
  end

  // Clocks since the current period began (the load edge counts as the first).
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (start_q || div_pulse_o) begin
      gap_q <= GAP_W'(1);
    end else begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  assert_period_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |-> (gap_q == n_exp));

  assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_pulse_o && !start_q) |=> ($stable(b_act) && $stable(a_act)));

  assert_err_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_in |=> cfg_err_o);

  assert_err_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_in |=> !cfg_err_o);

  assert_cfg_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_act >= B_W'(B_MIN)) && ({{(B_W-A_W){1'b0}}, a_act} <= b_act));

endmodule

bind fbdiv_dualmod fbdiv_dualmod_chk #(
  .B_W  (B_W),
  .A_W  (A_W),
  .B_MIN(B_MIN)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .b_val_i    (b_val_i),
  .a_val_i    (a_val_i),
  .div_pulse_o(div_pulse_o),
  .cfg_err_o  (cfg_err_o),
  .start_q    (start_q),
  .b_act      (b_act),
  .a_act      (a_act)
);

// File: tb/fbdiv_dualmod_tb_top.sv
module fbdiv_dualmod_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] b_v;
  logic [1:0] a_v;
  logic       pulse;
  logic       err;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  fbdiv_dualmod dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .b_val_i    (b_v),
    .a_val_i    (a_v),
    .div_pulse_o(pulse),
    .cfg_err_o  (err)
  );

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Counts falling edges until one shows the pulse high.
  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < 1000);
  endtask

  task automatic apply_reset(int b, int a);
    @(negedge clk);
    rst_n = 1'b0;
    b_v   = 6'(b);
    a_v   = 2'(a);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state;
    int n;
    apply_reset(4, 0);
    check("R7", "pulse in reset", int'(pulse), 0);
    check("R7", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    count_to_pulse(n);
    check("R3", "first period B=4 A=0", n, 16);
  endtask

  task automatic t_first_pulse;
    int n;
    apply_reset(10, 1);
    rst_n = 1'b1;
    count_to_pulse(n);
    check("R3", "first period B=10 A=1", n, 41);
    count_to_pulse(n);
    check("R1", "second period B=10 A=1", n, 41);
  endtask

  task automatic t_reset_illegal;
    int m;
    apply_reset(2, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5", "err after illegal at reset", int'(err), 1);
    count_to_pulse(m);
    check("R7", "default period after illegal reset", 1 + m, 16);
  endtask

  task automatic t_sweep;
    int n;
    for (int b = 4; b <= 63; b++) begin
      for (int a = 0; a <= 3; a++) begin
        b_v = 6'(b);
        a_v = 2'(a);
        count_to_pulse(n);
        if (n != 4 * b + a)
          $display("FAIL R1 sweep B=%0d A=%0d: actual %0d expected %0d", b, a, n, 4 * b + a);
        n_cmp++;
        if (n != 4 * b + a) n_bad++;
      end
    end
  endtask

  task automatic t_width;
    int n;
    b_v = 6'd4;
    a_v = 2'd0;
    count_to_pulse(n);
    check("R1", "minimum ratio", n, 16);
    @(negedge clk);
    check("R2", "pulse low after one clock (N=16)", int'(pulse), 0);
    count_to_pulse(n);
    b_v = 6'd63;
    a_v = 2'd3;
    count_to_pulse(n);
    check("R1", "maximum ratio", n, 255);
    @(negedge clk);
    check("R2", "pulse low after one clock (N=255)", int'(pulse), 0);
    count_to_pulse(n);
  endtask

  task automatic t_midchange;
    int n;
    int m;
    b_v = 6'd10;
    a_v = 2'd2;
    count_to_pulse(n);
    check("R1", "period B=10 A=2", n, 42);
    repeat (5) @(negedge clk);
    b_v = 6'd20;
    a_v = 2'd1;
    count_to_pulse(m);
    check("R4", "period unchanged by mid-period write", 5 + m, 42);
    count_to_pulse(n);
    check("R4", "new setting in following period", n, 81);
  endtask

  task automatic t_illegal;
    int n;
    int m;
    b_v = 6'd12;
    a_v = 2'd3;
    count_to_pulse(n);
    check("R1", "period B=12 A=3", n, 51);
    b_v = 6'd3;
    a_v = 2'd0;
    @(negedge clk);
    check("R5", "err for B=3", int'(err), 1);
    count_to_pulse(m);
    check("R6", "period held with B=3", 1 + m, 51);
    b_v = 6'd2;
    a_v = 2'd3;
    count_to_pulse(n);
    check("R6", "period held with A>B", n, 51);
    check("R5", "err for A>B", int'(err), 1);
    b_v = 6'd20;
    a_v = 2'd0;
    @(negedge clk);
    check("R5", "err cleared by legal pair", int'(err), 0);
    count_to_pulse(m);
    check("R1", "period after recovery B=20 A=0", 1 + m, 80);
  endtask

  initial begin
    rst_n = 1'b0;
    b_v   = 6'd4;
    a_v   = 2'd0;
    t_reset_state();
    t_first_pulse();
    t_reset_illegal();
    t_width();
    t_midchange();
    t_illegal();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule